// File: doc/BRIEF.md
# SD Command Path Engine

This block issues a single command to an SD or MMC card over the one-bit CMD line and, when asked to, collects the card's reply. A host-side controller supplies a 6-bit command index, a 32-bit argument, a 2-bit reply-type code and two qualifiers (data-transfer and stop-transmission). It then pulses `start` with `cmd_en` high. The engine builds a 48-bit frame, appends a CRC7, and shifts the frame out MSB first, one bit per card-clock enable. After that it either finishes at once or listens for a reply.

A reply is recognised by its start bit. Short replies are 48 bits, and the 32 content bits land in `rsp0`. Long replies are 136 bits and fill `rsp0` (first received) through `rsp3`. A CRC7 is computed over the covered bits of the reply and compared with the received one, except for the type that asks for no checking. Four sticky flags report how the command ended, and `busy` marks the span from acceptance to that ending. The CMD line is modelled as a separate output, output enable and input. All line activity advances only on cycles where `cclk_en` is high.

Top module: `sd_cmd_engine`

## Requirements
- R1: The transmitted frame is, MSB first: 0, 1, index[5:0], argument[31:0], CRC7 (polynomial x^7+x^3+1, initial value 0) over the preceding 40 bits, and 1. Each bit is driven with `cmd_oe` high for one `cclk_en` period, and the line is released on the following tick.
- R2: A command is accepted only on a cycle with `start` and `cmd_en` both high while `busy` is low. A start with `cmd_en` low, or a start during `busy`, has no effect on the line, the frame or the latched qualifiers.
- R3: With reply type 0 (none), flag bit 0 (sent) is set on the tick that releases the line, and no reply is awaited.
- R4: With reply type 1 (short, checked), a 48-bit reply whose CRC7 over its first 40 bits matches sets flag bit 1 (reply received). Its bits 39..8 are stored in `rsp0`.
- R5: With reply type 3 (long), a 136-bit reply is taken. The 128 bits that follow its first 8 bits are stored MSB first in `rsp0`..`rsp3`. The CRC7 is taken over the 120 bits that follow those first 8 bits and is checked against the next 7 bits.
- R6: With reply type 1 or 3, a CRC7 mismatch sets flag bit 2 (CRC fail) instead of bit 1.
- R7: With reply type 2 (short, unchecked), the CRC field is ignored and flag bit 1 is set even when it is wrong. Flag bit 2 never rises for this type.
- R8: When a reply is expected and `cmd_i` stays high for 64 ticks after the line is released, flag bit 3 (timeout) is set. A start bit seen on the 64th tick is still accepted.
- R9: `xfer_flag` and `stop_flag` hold the data-transfer and stop qualifiers of the last accepted command.
- R10: Flags are sticky, and each is cleared only by a one in the same bit of `flag_clr`.
- R11: `busy` rises on the cycle after acceptance and falls on the edge where exactly one terminal flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk_en | input | 1 | Card-clock enable; line drive and sampling advance on it |
| start | input | 1 | Command launch pulse |
| cmd_en | input | 1 | Command enable qualifier for `start` |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0 none, 1 short checked, 2 short unchecked, 3 long |
| xfer_req | input | 1 | Marks a data-transfer command |
| stop_req | input | 1 | Marks a stop-transmission command |
| flag_clr | input | 4 | Write-one-to-clear for flags |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input value |
| busy | output | 1 | Command in progress |
| flags | output | 4 | Sticky flags: 0 sent, 1 reply, 2 CRC fail, 3 timeout |
| xfer_flag | output | 1 | Latched data-transfer qualifier |
| stop_flag | output | 1 | Latched stop qualifier |
| rsp0 | output | 32 | Reply word 0 (short content or first long word) |
| rsp1 | output | 32 | Reply word 1 |
| rsp2 | output | 32 | Reply word 2 |
| rsp3 | output | 32 | Reply word 3 (last long word incl. CRC and end bit) |

## Verification
The hardest case to reach is the edge of the reply window: a card that holds the line high for exactly 63 ticks after release and starts its reply on the 64th. The bench card model counts ticks from the one where it sees `cmd_oe` drop. It inserts that exact delay and checks that the reply is accepted, while full silence must end in a timeout. A second awkward case is a new start pulse in the middle of a frame. The bench injects one partway through the shift-out and compares the captured frame and qualifiers against the first command.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int IDX_W    = 6;
  localparam int ARG_W    = 32;
  localparam int CRC_W    = 7;
  localparam int BODY_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W  = BODY_W + CRC_W + 1;
  localparam int NFLAGS   = 4;

  localparam int F_SENT = 0;
  localparam int F_RESP = 1;
  localparam int F_CRC  = 2;
  localparam int F_TMO  = 3;

  typedef enum logic [1:0] {
    RSP_NONE        = 2'd0,
    RSP_SHORT       = 2'd1,
    RSP_SHORT_NOCRC = 2'd2,
    RSP_LONG        = 2'd3
  } rsp_kind_e;

  function automatic logic [CRC_W-1:0] crc7_body(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & 7'h09);
    end
    return c;
  endfunction

endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  logic fb;
  assign fb = din ^ crc[6];

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc <= '0;
    else if (en)
      crc <= {crc[5:0], 1'b0} ^ ({7{fb}} & 7'h09);
  end
endmodule

// File: rtl/sdc_tx.sv
module sdc_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               cmd_o,
  output logic               cmd_oe,
  output logic               done
);
  localparam int REM_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [REM_W-1:0]   rem;
  logic               active;

  assign done = tick & active & (rem == '0) & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      rem    <= '0;
      active <= 1'b0;
      cmd_o  <= 1'b1;
      cmd_oe <= 1'b0;
    end else if (load) begin
      sr     <= frame;
      rem    <= REM_W'(FRAME_W);
      active <= 1'b1;
    end else if (tick && active) begin
      if (rem != '0) begin
        cmd_o  <= sr[FRAME_W-1];
        cmd_oe <= 1'b1;
        sr     <= {sr[FRAME_W-2:0], 1'b0};
        rem    <= rem - 1'b1;
      end else begin
        cmd_o  <= 1'b1;
        cmd_oe <= 1'b0;
        active <= 1'b0;
      end
    end
  end

  // R1
  oe_active_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> active);

endmodule

// File: rtl/sdc_rx.sv
module sdc_rx #(
  parameter int TMO       = 64,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int SR_W      = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            arm,
  input  logic            long_mode,
  input  logic            cmd_i,
  output logic            done,
  output logic            timeout,
  output logic            crc_ok,
  output logic [SR_W-1:0] sr_next
);
  localparam int CNT_W        = $clog2(LONG_LEN);
  localparam int TMR_W        = $clog2(TMO);
  localparam int SHORT_CRC_AT = SHORT_LEN - 9;
  localparam int LONG_HDR     = 7;
  localparam int LONG_CRC_AT  = LONG_LEN - 9;
  localparam logic [TMR_W-1:0] TMR_LAST   = TMR_W'(TMO - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 2);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 2);

  logic             hunting, receiving;
  logic [CNT_W-1:0] cnt, last;
  logic [TMR_W-1:0] tmr;
  logic [SR_W-1:0]  sr;
  logic [6:0]       crc_val;
  logic             in_win;

  assign last    = long_mode ? LONG_LAST : SHORT_LAST;
  assign in_win  = long_mode ? ((cnt >= CNT_W'(LONG_HDR)) && (cnt < CNT_W'(LONG_CRC_AT)))
                             : (cnt < CNT_W'(SHORT_CRC_AT));
  assign sr_next = {sr[SR_W-2:0], cmd_i};
  assign done    = tick & receiving & (cnt == last);
  assign timeout = tick & hunting & cmd_i & (tmr == TMR_LAST);
  assign crc_ok  = (crc_val == sr[6:0]);

  sdc_crc7 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (arm),
    .en  (tick & receiving & in_win),
    .din (cmd_i),
    .crc (crc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hunting   <= 1'b0;
      receiving <= 1'b0;
      cnt       <= '0;
      tmr       <= '0;
      sr        <= '0;
    end else if (arm) begin
      hunting   <= 1'b1;
      receiving <= 1'b0;
      cnt       <= '0;
      tmr       <= '0;
    end else if (tick && hunting) begin
      if (!cmd_i) begin
        hunting   <= 1'b0;
        receiving <= 1'b1;
        cnt       <= '0;
      end else if (tmr == TMR_LAST) begin
        hunting <= 1'b0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (tick && receiving) begin
      sr  <= sr_next;
      cnt <= cnt + 1'b1;
      if (cnt == last)
        receiving <= 1'b0;
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    receiving |-> (cnt <= last));

  // R8
  start_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (hunting && tick && !cmd_i && !arm) |=> receiving);

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TMO_TICKS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cclk_en,
  input  logic        start,
  input  logic        cmd_en,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  rsp_kind,
  input  logic        xfer_req,
  input  logic        stop_req,
  input  logic [3:0]  flag_clr,
  output logic        cmd_o,
  output logic        cmd_oe,
  input  logic        cmd_i,
  output logic        busy,
  output logic [3:0]  flags,
  output logic        xfer_flag,
  output logic        stop_flag,
  output logic [31:0] rsp0,
  output logic [31:0] rsp1,
  output logic [31:0] rsp2,
  output logic [31:0] rsp3
);
  localparam int SR_W = 4 * ARG_W;

  rsp_kind_e          kind_q;
  logic               accept;
  logic [BODY_W-1:0]  body;
  logic [FRAME_W-1:0] frame;
  logic               tx_done, rx_done, rx_to, rx_crc_ok, rx_arm;
  logic [SR_W-1:0]    rx_sr;
  logic [NFLAGS-1:0]  set_vec;

  assign accept = start & cmd_en & ~busy;
  assign body   = {1'b0, 1'b1, cmd_idx, cmd_arg};
  assign frame  = {body, crc7_body(body), 1'b1};
  assign rx_arm = tx_done & (kind_q != RSP_NONE);

  sdc_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick   (cclk_en),
    .load   (accept),
    .frame  (frame),
    .cmd_o  (cmd_o),
    .cmd_oe (cmd_oe),
    .done   (tx_done)
  );

  sdc_rx #(.TMO(TMO_TICKS), .SHORT_LEN(FRAME_W), .LONG_LEN(SR_W + 8), .SR_W(SR_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (cclk_en),
    .arm       (rx_arm),
    .long_mode (kind_q == RSP_LONG),
    .cmd_i     (cmd_i),
    .done      (rx_done),
    .timeout   (rx_to),
    .crc_ok    (rx_crc_ok),
    .sr_next   (rx_sr)
  );

  always_comb begin
    set_vec = '0;
    if (tx_done && kind_q == RSP_NONE)
      set_vec[F_SENT] = 1'b1;
    if (rx_done) begin
      if (kind_q != RSP_SHORT_NOCRC && !rx_crc_ok)
        set_vec[F_CRC] = 1'b1;
      else
        set_vec[F_RESP] = 1'b1;
    end
    if (rx_to)
      set_vec[F_TMO] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      flags     <= '0;
      kind_q    <= RSP_NONE;
      xfer_flag <= 1'b0;
      stop_flag <= 1'b0;
      rsp0      <= '0;
      rsp1      <= '0;
      rsp2      <= '0;
      rsp3      <= '0;
    end else begin
      flags <= set_vec | (flags & ~flag_clr);
      if (accept) begin
        busy      <= 1'b1;
        kind_q    <= rsp_kind_e'(rsp_kind);
        xfer_flag <= xfer_req;
        stop_flag <= stop_req;
      end else if (set_vec != '0) begin
        busy <= 1'b0;
      end
      if (rx_done) begin
        if (kind_q == RSP_LONG) begin
          rsp0 <= rx_sr[127:96];
          rsp1 <= rx_sr[95:64];
          rsp2 <= rx_sr[63:32];
          rsp3 <= rx_sr[31:0];
        end else begin
          rsp0 <= rx_sr[39:8];
        end
      end
    end
  end

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (flags != '0));

  // R1
  oe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy);

  // R7
  nocrc_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_q == RSP_SHORT_NOCRC) |=> !$rose(flags[F_CRC]));

  // R2
  hold_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(xfer_flag) && $stable(stop_flag)));

  // R8
  tmo_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_TMO]) |-> ($past(kind_q) != RSP_NONE));

endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cclk_en = 1'b0;
  logic        start = 1'b0, cmd_en = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  rsp_kind = '0;
  logic        xfer_req = 1'b0, stop_req = 1'b0;
  logic [3:0]  flag_clr = '0;
  logic        cmd_o, cmd_oe;
  logic        cmd_i = 1'b1;
  logic        busy;
  logic [3:0]  flags;
  logic        xfer_flag, stop_flag;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;

  int checks = 0;
  int fails  = 0;
  logic [1:0] div = '0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div     <= div + 1'b1;
    cclk_en <= (div == 2'd3);
  end

  sd_cmd_engine u_sd_cmd_engine (
    .clk(clk), .rst(rst), .cclk_en(cclk_en), .start(start), .cmd_en(cmd_en),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind),
    .xfer_req(xfer_req), .stop_req(stop_req), .flag_clr(flag_clr),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i), .busy(busy), .flags(flags),
    .xfer_flag(xfer_flag), .stop_flag(stop_flag),
    .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Remainder of data(x)*x^7 divided by x^7+x^3+1; data right-aligned, n bits
  function automatic logic [6:0] ref_crc(input logic [135:0] data, input int n);
    logic [142:0] m;
    m = {data, 7'b0};
    for (int i = n + 6; i >= 7; i--)
      if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    return m[6:0];
  endfunction

  task automatic next_tick();
    @(posedge clk iff cclk_en);
    @(negedge clk);
  endtask

  task automatic run_cmd(input int kind, input int mode, input logic [5:0] idx,
                         input logic [31:0] arg, input bit xf, input bit sp,
                         input int d, input bit inject);
    logic [47:0]  got_frame, exp_frame;
    logic [39:0]  body;
    logic [38:0]  sbody;
    logic [31:0]  argr;
    logic [119:0] content;
    logic [6:0]   c;
    logic [135:0] rv;
    logic [3:0]   exp_flags;
    int nbits, got, guard, w;
    string rq;

    body      = {2'b01, idx, arg};
    exp_frame = {body, ref_crc({96'b0, body}, 40), 1'b1};
    argr      = arg ^ 32'h5A5A_0F0F;
    content   = {arg, ~arg, arg ^ 32'h1234_5678, arg[23:0]};
    if (kind == 3) begin
      c     = ref_crc({16'b0, content}, 120) ^ {6'b0, mode == 1};
      rv    = {2'b00, 6'h3F, content, c, 1'b1};
      nbits = 136;
    end else begin
      sbody = {1'b0, idx, argr};
      c     = ref_crc({97'b0, sbody}, 39) ^ {6'b0, mode == 1};
      rv    = {1'b0, sbody, c, 1'b1, 88'b0};
      nbits = 48;
    end

    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; rsp_kind = kind[1:0];
    xfer_req = xf; stop_req = sp; cmd_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R11", "busy after accept", 128'(busy), 128'(1));

    got = 0; guard = 0; got_frame = '0;
    while (guard < 300) begin
      next_tick();
      guard++;
      if (cmd_oe) begin
        got_frame = {got_frame[46:0], cmd_o};
        got++;
        if (inject && got == 10) begin
          cmd_idx = ~idx; cmd_arg = ~arg; xfer_req = ~xf; stop_req = ~sp; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end else if (got >= 48) begin
        break;
      end
    end
    check(got == 48 && got_frame === exp_frame, inject ? "R2" : "R1", "command frame",
          128'(got_frame), 128'(exp_frame));

    if (kind != 0 && mode != 2) begin
      repeat (d) next_tick();
      for (int i = 0; i < nbits; i++) begin
        cmd_i = rv[135 - i];
        next_tick();
      end
      cmd_i = 1'b1;
    end

    w = 0;
    while (busy && w < 2000) begin
      @(negedge clk);
      w++;
    end

    if (kind == 0)                       begin exp_flags = 4'b0001; rq = "R3"; end
    else if (mode == 2)                  begin exp_flags = 4'b1000; rq = "R8"; end
    else if (mode == 1 && kind != 2)     begin exp_flags = 4'b0100; rq = "R6"; end
    else if (mode == 1)                  begin exp_flags = 4'b0010; rq = "R7"; end
    else if (kind == 3)                  begin exp_flags = 4'b0010; rq = "R5"; end
    else                                 begin exp_flags = 4'b0010; rq = "R4"; end

    check(flags === exp_flags, rq, "flags", 128'(flags), 128'(exp_flags));
    check(busy === 1'b0 && cmd_oe === 1'b0, "R11", "idle after end",
          128'({busy, cmd_oe}), 128'(0));
    check(xfer_flag === xf && stop_flag === sp, "R9", "qualifiers",
          128'({xfer_flag, stop_flag}), 128'({xf, sp}));
    if (kind != 0 && mode == 0) begin
      if (kind == 3)
        check({rsp0, rsp1, rsp2, rsp3} === {content, c, 1'b1}, "R5", "long words",
              {rsp0, rsp1, rsp2, rsp3}, {content, c, 1'b1});
      else
        check(rsp0 === argr, "R4", "short word", 128'(rsp0), 128'(argr));
    end

    // R10: clearing other bits keeps the flag, clearing its own bit drops it
    flag_clr = ~exp_flags;
    @(negedge clk);
    flag_clr = '0;
    check(flags === exp_flags, "R10", "sticky flags", 128'(flags), 128'(exp_flags));
    flag_clr = exp_flags;
    @(negedge clk);
    flag_clr = '0;
    check(flags === 4'b0, "R10", "flags cleared", 128'(flags), 128'(0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && flags === 4'b0 && cmd_oe === 1'b0 && cmd_o === 1'b1,
          "R11", "reset state", 128'({busy, flags, cmd_oe, cmd_o}), 128'(1));

    // R2: start without enable is ignored
    start = 1'b1; cmd_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen_oe;
      seen_oe = 1'b0;
      repeat (16) begin
        @(negedge clk);
        if (cmd_oe || busy) seen_oe = 1'b1;
      end
      check(!seen_oe, "R2", "start without enable", 128'(seen_oe), 128'(0));
    end

    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 3; m++)
        for (int p = 0; p < 2; p++)
          run_cmd(k, m, p ? 6'h0C : 6'h11, p ? 32'hFFFF_0001 : 32'h1234_5678,
                  p == 0, p == 1, p ? 63 : 0, 1'b0);

    run_cmd(1, 0, 6'h3F, 32'h0000_0000, 1'b1, 1'b1, 5, 1'b0);
    run_cmd(0, 0, 6'h29, 32'hC0FF_EE00, 1'b1, 1'b0, 0, 1'b1);
    run_cmd(3, 0, 6'h02, 32'h8000_0001, 1'b0, 1'b1, 2, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule